// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block decides when a small 8-bit controller core leaves its program to serve an interrupt, and it carries out the entry. It looks at four inputs: a reset request, a vector of pending hardware sources, the global interrupt enable flag, and the current word program counter together with the stack pointer. When entry is allowed, it latches the winning vector and the return address. It then writes the return address to a byte-wide stack port, one byte per clock. Finally it presents the new program counter, the updated stack pointer, a request to clear the global enable, and a one-hot mask naming the pending bit that has been served.

Parameters set four things: the number of hardware sources, the program counter width (one, two or three bytes), whether the core has long jump/call (which doubles the vector slot size), and the stack pointer width. The surrounding core owns the enable flag and the pending register. It applies the clear requests during the cycle in which `done_o` is high.

Top module: `irq_entry_seq`

## Requirements
- R1: While `gie_i` is low at a rising clock edge in the idle state, no entry starts, even with requests present. `busy_o` and `st_we_o` stay low.
- R2: A reset request takes precedence over pending hardware sources. It enters at vector number 0, so `new_pc_o` is 0. It raises `rst_ack_o` with `done_o` and leaves `pend_clr_o` at zero.
- R3: Without a reset request, the pending source with the lowest set bit index i wins, and the vector number is i+1.
- R4: When a hardware entry completes, `pend_clr_o` carries exactly one set bit, the one at the served index, and only while `done_o` is high. All other bits are left alone, so the result is equivalent to pending & (pending-1).
- R5: `new_pc_o` equals the vector number times the slot size. The slot size is 2 words when `LONG_JUMP`=1 and 1 word when it is 0.
- R6: The return address is written low byte first, then the middle byte, then the high byte. The first byte goes to the stack pointer value taken at acceptance, and each following write goes to an address one lower.
- R7: Exactly `PC_BYTES` stack writes are made, one per clock with no gaps. `sp_new_o` at `done_o` equals the accepted stack pointer minus `PC_BYTES`, with modulo wrap.
- R8: `gie_clr_o` is a one-cycle pulse that coincides with `done_o`.
- R9: `busy_o` rises the cycle after acceptance and stays high through the done cycle. `done_o` is a single-cycle pulse in the cycle after the last stack write.
- R10: Changes to `pend_i`, `rst_req_i`, `pc_i` or `sp_i` after acceptance do not change the vector, written bytes, addresses or results of the entry in progress.
- R11: With no reset request and an all-zero pending vector, no entry starts, even while `gie_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | 1 | Pending reset request |
| pend_i | input | NUM_SRC | Pending hardware sources, bit i is source i |
| gie_i | input | 1 | Global interrupt enable flag |
| pc_i | input | 8*PC_BYTES | Current word program counter (return address) |
| sp_i | input | SP_W | Current stack pointer |
| busy_o | output | 1 | Entry in progress |
| st_we_o | output | 1 | Stack byte write strobe |
| st_addr_o | output | SP_W | Stack byte write address |
| st_data_o | output | 8 | Stack byte write data |
| done_o | output | 1 | Entry complete; load new PC and SP this cycle |
| new_pc_o | output | 8*PC_BYTES | Vector target, valid with done_o |
| sp_new_o | output | SP_W | Stack pointer after the pushes, valid with done_o |
| gie_clr_o | output | 1 | Clear the global enable flag |
| pend_clr_o | output | NUM_SRC | One-hot mask of the pending bit to retire |
| rst_ack_o | output | 1 | The reset request has been served |

## Verification
The assertions assume the core acts on `gie_clr_o` in the same cycle it sees it, so `gie_i` is low again by the edge after `done_o`. Otherwise the idle state would take a second entry straight away. They also assume `rst_n` is the only way to abort an entry. The bench models the enable flag and the pending register as the core would: it clears the served bit and the enable on the done cycle. It reopens the enable only once the sequencer is idle again. During each push it scrambles every request and address input, so the latched values are stressed without breaking these assumptions.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_PUSH = 2'd1,
      SEQ_DONE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   logic [N-1:0] below;   // bit i set when some lower bit is set

   assign below[0] = 1'b0;
   generate
      for (genvar g = 1; g < N; g++) begin : g_chain
         assign below[g] = below[g-1] | req[g-1];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !below[i]) idx = IDX_W'(i);
      end
   end

   assign any = |req;
endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
   parameter int IDX_W     = 3,
   parameter int PC_W      = 16,
   parameter bit LONG_JUMP = 1'b1
) (
   input  logic             is_rst,
   input  logic [IDX_W-1:0] idx,
   output logic [PC_W-1:0]  target
);
   localparam int VEC_W = IDX_W + 1;
   logic [VEC_W-1:0] vec;

   assign vec = is_rst ? '0 : (VEC_W'(idx) + VEC_W'(1));

   generate
      if (LONG_JUMP) begin : g_two_word
         assign target = PC_W'({vec, 1'b0});
      end else begin : g_one_word
         assign target = PC_W'(vec);
      end
   endgenerate
endmodule

// File: rtl/irq_push_ctrl.sv
module irq_push_ctrl #(
   parameter int PC_BYTES = 2,
   parameter int SP_W     = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [8*PC_BYTES-1:0] pc_in,
   input  logic [SP_W-1:0]       sp_in,
   output logic                  we,
   output logic                  last,
   output logic [SP_W-1:0]       addr,
   output logic [7:0]            data
);
   localparam int PC_W  = 8 * PC_BYTES;
   localparam int CNT_W = 2;

   logic [PC_W-1:0]  ret_q;
   logic [SP_W-1:0]  sp_q;
   logic [CNT_W-1:0] cnt_q;
   logic             act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q <= '0;
         sp_q  <= '0;
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (start && !act_q) begin
         ret_q <= pc_in;
         sp_q  <= sp_in;
         cnt_q <= '0;
         act_q <= 1'b1;
      end else if (act_q) begin
         sp_q  <= sp_q - SP_W'(1);
         cnt_q <= cnt_q + CNT_W'(1);
         if (last) act_q <= 1'b0;
      end
   end

   generate
      if (PC_BYTES == 1) begin : g_single
         assign data = ret_q[7:0];
         assign last = act_q;
      end else begin : g_multi
         assign data = ret_q[8*cnt_q +: 8];
         assign last = act_q && (cnt_q == CNT_W'(PC_BYTES - 1));
      end
   endgenerate

   assign we   = act_q;
   assign addr = sp_q;

   // R6: successive writes walk downward by one
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we)) |-> (addr == $past(addr) - SP_W'(1)));
   // R10: latched return address holds for the whole push
   a_r10_ret_held: assert property (@(posedge clk) disable iff (!rst_n)
      (we && $past(we)) |-> $stable(ret_q));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_seq_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int PC_BYTES  = 2,
   parameter bit LONG_JUMP = 1'b1,
   parameter int SP_W      = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rst_req_i,
   input  logic [NUM_SRC-1:0]    pend_i,
   input  logic                  gie_i,
   input  logic [8*PC_BYTES-1:0] pc_i,
   input  logic [SP_W-1:0]       sp_i,
   output logic                  busy_o,
   output logic                  st_we_o,
   output logic [SP_W-1:0]       st_addr_o,
   output logic [7:0]            st_data_o,
   output logic                  done_o,
   output logic [8*PC_BYTES-1:0] new_pc_o,
   output logic [SP_W-1:0]       sp_new_o,
   output logic                  gie_clr_o,
   output logic [NUM_SRC-1:0]    pend_clr_o,
   output logic                  rst_ack_o
);
   localparam int PC_W  = 8 * PC_BYTES;
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (PC_BYTES < 1 || PC_BYTES > 3) begin : g_bad_pc
         $error("PC_BYTES must be 1, 2 or 3");
      end
      if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
         $error("NUM_SRC must lie in 1..32");
      end
      if (SP_W < 8 || SP_W > 32) begin : g_bad_sp
         $error("SP_W must lie in 8..32");
      end
   endgenerate

   seq_state_t       st_q;
   logic             pick_any;
   logic [IDX_W-1:0] pick_idx;
   logic             is_rst_q;
   logic [IDX_W-1:0] idx_q;
   logic             accept;
   logic             push_last;
   logic             push_we;

   irq_prio_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
      .req (pend_i),
      .any (pick_any),
      .idx (pick_idx)
   );

   assign accept = (st_q == SEQ_IDLE) && gie_i && (rst_req_i || pick_any);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         is_rst_q <= 1'b0;
         idx_q    <= '0;
      end else begin
         case (st_q)
            SEQ_IDLE: if (accept) begin
               st_q     <= SEQ_PUSH;
               is_rst_q <= rst_req_i;
               idx_q    <= pick_idx;
            end
            SEQ_PUSH: if (push_last) st_q <= SEQ_DONE;
            default:  st_q <= SEQ_IDLE;
         endcase
      end
   end

   irq_push_ctrl #(.PC_BYTES(PC_BYTES), .SP_W(SP_W)) u_push (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .pc_in (pc_i),
      .sp_in (sp_i),
      .we    (push_we),
      .last  (push_last),
      .addr  (st_addr_o),
      .data  (st_data_o)
   );

   irq_vec_addr #(.IDX_W(IDX_W), .PC_W(PC_W), .LONG_JUMP(LONG_JUMP)) u_vec (
      .is_rst (is_rst_q),
      .idx    (idx_q),
      .target (new_pc_o)
   );

   assign st_we_o    = push_we;
   assign busy_o     = (st_q != SEQ_IDLE);
   assign done_o     = (st_q == SEQ_DONE);
   assign sp_new_o   = st_addr_o;
   assign gie_clr_o  = done_o;
   assign rst_ack_o  = done_o && is_rst_q;
   assign pend_clr_o = (done_o && !is_rst_q) ? (NUM_SRC'(1) << idx_q) : '0;

   // R1: an entry only begins after the enable was seen high
   a_r1_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(gie_i));
   // R11: nothing to serve keeps the sequencer idle
   a_r11_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !rst_req_i && pend_i == '0) |=> !busy_o);
   // R4: at most one pending bit retired, and only at completion
   a_r4_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pend_clr_o) && ((pend_clr_o != '0) -> done_o));
   // R2: reset entry targets address zero and retires no source
   a_r2_reset_vec: assert property (@(posedge clk) disable iff (!rst_n)
      rst_ack_o |-> (new_pc_o == '0 && pend_clr_o == '0));
   // R9: done is a single cycle following the last stack write
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(push_last) && !st_we_o));
   a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R7: writes never pause once started until the last one
   a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (st_we_o && !push_last) |=> st_we_o);
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
   localparam int NS  = 8;
   localparam int PB  = 2;
   localparam bit LJ  = 1'b1;
   localparam int SPW = 16;
   localparam int PCW = 8 * PB;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           rst_req_i = 1'b0;
   logic [NS-1:0]  pend_i = '0;
   logic           gie_i = 1'b0;
   logic [PCW-1:0] pc_i = '0;
   logic [SPW-1:0] sp_i = '0;
   logic           busy_o, st_we_o, done_o, gie_clr_o, rst_ack_o;
   logic [SPW-1:0] st_addr_o, sp_new_o;
   logic [7:0]     st_data_o;
   logic [PCW-1:0] new_pc_o;
   logic [NS-1:0]  pend_clr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   irq_entry_seq #(.NUM_SRC(NS), .PC_BYTES(PB), .LONG_JUMP(LJ), .SP_W(SPW)) dut (
      .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .pend_i(pend_i),
      .gie_i(gie_i), .pc_i(pc_i), .sp_i(sp_i), .busy_o(busy_o),
      .st_we_o(st_we_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o),
      .done_o(done_o), .new_pc_o(new_pc_o), .sp_new_o(sp_new_o),
      .gie_clr_o(gie_clr_o), .pend_clr_o(pend_clr_o), .rst_ack_o(rst_ack_o)
   );

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_vec(input bit r, input logic [NS-1:0] p);
      if (r) return 0;
      for (int i = 0; i < NS; i++) if (p[i]) return i + 1;
      return -1;
   endfunction

   function automatic logic [NS-1:0] exp_clr(input bit r, input logic [NS-1:0] p);
      if (r) return '0;
      return p & ~(p - NS'(1));
   endfunction

   // one full entry; caller has set inputs at a negedge with gie high
   task automatic entry(input bit scramble);
      bit             r  = rst_req_i;
      logic [NS-1:0]  p  = pend_i;
      logic [PCW-1:0] pc = pc_i;
      logic [SPW-1:0] sp = sp_i;
      int             v  = exp_vec(r, p);
      @(posedge clk);
      for (int k = 0; k < PB; k++) begin
         @(negedge clk);
         chk(busy_o == 1'b1, "R9 busy during push", 32'(busy_o), 1);
         chk(st_we_o == 1'b1 && done_o == 1'b0, "R7 write each push cycle",
             32'(st_we_o), 1);
         chk(st_addr_o == sp - SPW'(k), "R6 push address", 32'(st_addr_o),
             32'(sp - SPW'(k)));
         chk(st_data_o == pc[8*k +: 8], "R6 push byte order", 32'(st_data_o),
             32'(pc[8*k +: 8]));
         if (scramble) begin   // R10
            pend_i    = NS'($urandom);
            rst_req_i = 1'($urandom);
            pc_i      = PCW'($urandom);
            sp_i      = SPW'($urandom);
         end
      end
      @(negedge clk);
      chk(done_o == 1'b1 && st_we_o == 1'b0, "R9 done after last write",
          32'(done_o), 1);
      chk(new_pc_o == PCW'(v * (LJ ? 2 : 1)), "R3 R5 R10 vector target",
          32'(new_pc_o), 32'(v * (LJ ? 2 : 1)));
      chk(sp_new_o == sp - SPW'(PB), "R7 final stack pointer", 32'(sp_new_o),
          32'(sp - SPW'(PB)));
      chk(gie_clr_o == 1'b1, "R8 enable clear with done", 32'(gie_clr_o), 1);
      chk(pend_clr_o == exp_clr(r, p), "R4 retired bit", 32'(pend_clr_o),
          32'(exp_clr(r, p)));
      chk(rst_ack_o == r, "R2 reset acknowledge", 32'(rst_ack_o), 32'(r));
      // core model: apply clears now
      gie_i     = 1'b0;
      rst_req_i = 1'b0;
      pend_i    = p & ~pend_clr_o;
      @(negedge clk);
      chk(busy_o == 1'b0 && done_o == 1'b0 && gie_clr_o == 1'b0,
          "R8 R9 single-cycle done", 32'(done_o), 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && st_we_o == 0 && done_o == 0 && pend_clr_o == 0,
          "reset state idle", 32'(busy_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: requests while disabled are ignored
      gie_i = 1'b0; rst_req_i = 1'b1; pend_i = 8'hFF;
      repeat (4) @(negedge clk);
      chk(busy_o == 0 && st_we_o == 0, "R1 disabled no entry", 32'(busy_o), 0);

      // R11: enabled but nothing pending
      gie_i = 1'b1; rst_req_i = 1'b0; pend_i = '0;
      repeat (4) @(negedge clk);
      chk(busy_o == 0 && st_we_o == 0, "R11 nothing pending no entry",
          32'(busy_o), 0);

      // R2: reset beats hardware sources
      rst_req_i = 1'b1; pend_i = 8'h06; pc_i = 16'hA55A; sp_i = 16'h0400;
      gie_i = 1'b1;
      entry(1'b0);
      chk(pend_i == 8'h06, "R2 pending untouched by reset entry",
          32'(pend_i), 32'h06);

      // R3/R4: lowest of several, then next one
      gie_i = 1'b1; pc_i = 16'h1234; sp_i = 16'h08FF;
      entry(1'b0);
      chk(pend_i == 8'h04, "R4 only lowest retired", 32'(pend_i), 32'h04);
      gie_i = 1'b1;
      entry(1'b0);

      // highest source alone, stack wrapping through zero
      pend_i = 8'h80; gie_i = 1'b1; pc_i = 16'hBEEF; sp_i = 16'h0000;
      entry(1'b1);

      // R10 + random mix
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         rst_req_i = ($urandom % 4) == 0;
         pend_i    = NS'($urandom);
         pc_i      = PCW'($urandom);
         sp_i      = SPW'($urandom);
         gie_i     = 1'b1;
         if (!rst_req_i && pend_i == '0) begin
            @(negedge clk);
            chk(busy_o == 0, "R11 random idle", 32'(busy_o), 0);
            gie_i = 1'b0;
         end else begin
            entry(1'b1);
         end
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule